// File: doc/BRIEF.md
# Sleep/Wake Power Sequencing Controller

This controller moves a device between a running mode and a low-power mode. While the device runs, every global clock enable is on and the I/O buffers are powered. A sleep request starts an ordered shutdown. First the I/O buffers are switched off after a programmable wait. After a second wait, every clock enable is dropped at once and a sleep flag is raised.

When the request is withdrawn, the controller waits a programmable time and then turns the clock enables back on in groups, least significant bits first. After a final programmable wait, the I/O buffers are powered again and the controller reports the running state. Each of the four waits comes from a 6-bit input. A value below the safe minimum for that wait is raised to the minimum.

A free-running cycle counter advances while the device is awake. It holds its value while the device sleeps. On the cycle the controller returns to the running state, the held value is copied to an exit-count output, and the counter then resumes.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in state code 0 (awake) with `clk_en` = 16'hFFFF, `io_en` = 1, `asleep` = 0 and `exit_count` = 0. The running counter restarts from zero.
- R2: `state` takes only these codes: 0 awake, 1 I/O shutdown wait, 2 clock shutdown wait, 3 asleep, 4 wake wait, 5 clock ramp, 6 I/O power-up wait.
- R3: Suppose `sleep_req` is high at the clock edge k while in the awake state. Then `state` is 1 after edge k, and `io_en` falls after edge k+T1. After edge k+T1+T2, `clk_en` is 0, `asleep` is 1 and `state` is 3. T1 and T2 are the effective values of `dly_io_off` and `dly_clk_off`.
- R4: Suppose `sleep_req` is low at edge m while in the asleep state. Then `asleep` is 0 and `state` is 4 after edge m, and `clk_en` first becomes non-zero after edge m+T3.
- R5: The clocks return in three groups, one per edge, in this order: bits 5:0, then bits 11:6, then bits 15:12. `clk_en` reads 16'h003F after edge m+T3, 16'h0FFF after m+T3+1 and 16'hFFFF after m+T3+2. At that last point `state` is 6.
- R6: `io_en` rises and `state` returns to 0 after edge m+T3+2+T4. In state 0, `io_en` is 1 and `clk_en` is all ones.
- R7: An effective delay is the programmed value or its minimum, whichever is larger. The minimums are 1 for T1, 11 for T2, 1 for T3 and 40 for T4.
- R8: If `sleep_req` is high at an edge while `state` is 4, 5 or 6, the exit is abandoned and `state` is 1 after that edge. `clk_en` and `io_en` keep their values, and the shutdown timing of R3 then runs from that edge.
- R9: The counter advances by one each cycle from reset until the edge that enters the asleep state. It is then frozen until the edge that re-enters state 0. That edge loads the frozen value into `exit_count`. `exit_count` holds at all other times.
- R10: A low `sleep_req` while `state` is 1 or 2 has no effect. The shutdown completes on the schedule of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | High requests sleep, low requests wake |
| dly_io_off | input | 6 | T1, wait before I/O power-down |
| dly_clk_off | input | 6 | T2, wait before clock shutdown |
| dly_clk_on | input | 6 | T3, wait before clock ramp |
| dly_io_on | input | 6 | T4, wait before I/O power-up |
| clk_en | output | 16 | Global clock enables |
| io_en | output | 1 | I/O buffer power enable |
| asleep | output | 1 | Sleep status flag |
| state | output | 3 | Current controller state code |
| exit_count | output | 16 | Counter value captured on wake |

## Verification
All outputs are registered, so each response becomes visible one edge after the sampled request plus the programmed waits. `state` moves one edge after the request. `io_en` drops T1 edges later and `asleep` comes T1+T2 edges later. On wake, the first clock group arrives T3 edges after the withdrawing edge, the ramp completes two edges after that, and `io_en` rises T4 edges after the ramp completes. The bench drives inputs and samples outputs on the falling edge. It advances a behavioural model on every rising edge and compares every output at the following falling edge. Directed checks count rising edges from a request to the observed change and compare that count with these sums, using the clamped delays.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE   = 3'd0,
    ST_IO_OFF  = 3'd1,
    ST_CLK_OFF = 3'd2,
    ST_ASLEEP  = 3'd3,
    ST_EXIT    = 3'd4,
    ST_RAMP    = 3'd5,
    ST_IO_ON   = 3'd6
  } pwr_st_e;

endpackage

// File: rtl/pwr_dly_clamp.sv
module pwr_dly_clamp #(
  parameter int W   = 6,
  parameter int MIN = 1
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] eff
);
  localparam logic [W-1:0] MIN_V = W'(MIN);

  always_comb begin
    eff = (raw < MIN_V) ? MIN_V : raw;
  end
endmodule

// File: rtl/pwr_dly_timer.sv
module pwr_dly_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] tmr_q;

  // limit is at least 1 after clamping, so limit-1 never wraps
  assign done = (tmr_q == (limit - W'(1)));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      tmr_q <= '0;
    end else if (!done) begin
      tmr_q <= tmr_q + W'(1);
    end
  end
endmodule

// File: rtl/pwr_clk_ramp.sv
module pwr_clk_ramp #(
  parameter int NCLK = 16,
  parameter int NGRP = 3,
  parameter int SW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            fill,
  input  logic [SW-1:0]   step,
  output logic [NCLK-1:0] en_q
);
  localparam int GW = (NCLK + NGRP - 1) / NGRP;

  for (genvar i = 0; i < NCLK; i++) begin : g_bit
    localparam int GRP = i / GW;
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i] <= 1'b1;
      end else if (clear) begin
        en_q[i] <= 1'b0;
      end else if (fill && (int'(step) >= GRP)) begin
        en_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_run_cnt.sv
module pwr_run_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze_set,
  input  logic             freeze_clr,
  output logic [CNT_W-1:0] exit_count
);
  logic [CNT_W-1:0] cnt_q;
  logic             frz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      frz_q      <= 1'b0;
      exit_count <= '0;
    end else begin
      if (!frz_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (freeze_set) begin
        frz_q <= 1'b1;
      end else if (freeze_clr) begin
        frz_q      <= 1'b0;
        exit_count <= cnt_q;
      end
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NCLK        = 16,
  parameter int NGRP        = 3,
  parameter int DLY_W       = 6,
  parameter int CNT_W       = 16,
  parameter int MIN_IO_OFF  = 1,
  parameter int MIN_CLK_OFF = 11,
  parameter int MIN_CLK_ON  = 1,
  parameter int MIN_IO_ON   = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic [DLY_W-1:0] dly_io_off,
  input  logic [DLY_W-1:0] dly_clk_off,
  input  logic [DLY_W-1:0] dly_clk_on,
  input  logic [DLY_W-1:0] dly_io_on,
  output logic [NCLK-1:0]  clk_en,
  output logic             io_en,
  output logic             asleep,
  output logic [2:0]       state,
  output logic [CNT_W-1:0] exit_count
);
  localparam int SW = (NGRP > 2) ? $clog2(NGRP) : 1;
  localparam logic [SW-1:0] LAST_STEP = SW'(NGRP - 2);

  pwr_st_e st_q, st_nxt;
  logic [DLY_W-1:0] t_io_off, t_clk_off, t_clk_on, t_io_on, t_sel;
  logic             t_done, t_restart;
  logic [SW-1:0]    step_q, fill_step;
  logic             ramp_fill, ramp_clr;
  logic             do_io_off, do_io_on, do_sleep, do_wake, do_exit;

  pwr_dly_clamp #(.W(DLY_W), .MIN(MIN_IO_OFF))  u_c1 (.raw(dly_io_off),  .eff(t_io_off));
  pwr_dly_clamp #(.W(DLY_W), .MIN(MIN_CLK_OFF)) u_c2 (.raw(dly_clk_off), .eff(t_clk_off));
  pwr_dly_clamp #(.W(DLY_W), .MIN(MIN_CLK_ON))  u_c3 (.raw(dly_clk_on),  .eff(t_clk_on));
  pwr_dly_clamp #(.W(DLY_W), .MIN(MIN_IO_ON))   u_c4 (.raw(dly_io_on),   .eff(t_io_on));

  always_comb begin
    case (st_q)
      ST_IO_OFF:  t_sel = t_io_off;
      ST_CLK_OFF: t_sel = t_clk_off;
      ST_EXIT:    t_sel = t_clk_on;
      ST_IO_ON:   t_sel = t_io_on;
      default:    t_sel = DLY_W'(1);
    endcase
  end

  pwr_dly_timer #(.W(DLY_W)) u_tmr (
    .clk(clk), .rst(rst), .restart(t_restart), .limit(t_sel), .done(t_done)
  );

  always_comb begin
    st_nxt    = st_q;
    ramp_fill = 1'b0;
    ramp_clr  = 1'b0;
    do_io_off = 1'b0;
    do_io_on  = 1'b0;
    do_sleep  = 1'b0;
    do_wake   = 1'b0;
    do_exit   = 1'b0;
    fill_step = '0;
    case (st_q)
      ST_AWAKE: if (sleep_req) st_nxt = ST_IO_OFF;
      ST_IO_OFF: if (t_done) begin
        st_nxt    = ST_CLK_OFF;
        do_io_off = 1'b1;
      end
      ST_CLK_OFF: if (t_done) begin
        st_nxt   = ST_ASLEEP;
        ramp_clr = 1'b1;
        do_sleep = 1'b1;
      end
      ST_ASLEEP: if (!sleep_req) begin
        st_nxt  = ST_EXIT;
        do_exit = 1'b1;
      end
      ST_EXIT: begin
        if (sleep_req) begin
          st_nxt = ST_IO_OFF;
        end else if (t_done) begin
          st_nxt    = ST_RAMP;
          ramp_fill = 1'b1;
        end
      end
      ST_RAMP: begin
        if (sleep_req) begin
          st_nxt = ST_IO_OFF;
        end else begin
          ramp_fill = 1'b1;
          fill_step = step_q + SW'(1);
          if (step_q == LAST_STEP) st_nxt = ST_IO_ON;
        end
      end
      ST_IO_ON: begin
        if (sleep_req) begin
          st_nxt = ST_IO_OFF;
        end else if (t_done) begin
          st_nxt   = ST_AWAKE;
          do_io_on = 1'b1;
          do_wake  = 1'b1;
        end
      end
      default: st_nxt = ST_AWAKE;
    endcase
  end

  assign t_restart = (st_nxt != st_q);

  pwr_clk_ramp #(.NCLK(NCLK), .NGRP(NGRP), .SW(SW)) u_ramp (
    .clk(clk), .rst(rst), .clear(ramp_clr), .fill(ramp_fill),
    .step(fill_step), .en_q(clk_en)
  );

  pwr_run_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .freeze_set(do_sleep), .freeze_clr(do_wake),
    .exit_count(exit_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_AWAKE;
      step_q <= '0;
      io_en  <= 1'b1;
      asleep <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      step_q <= (st_q == ST_RAMP && !sleep_req) ? step_q + SW'(1) : '0;
      if (do_io_off) io_en <= 1'b0;
      else if (do_io_on) io_en <= 1'b1;
      if (do_sleep) asleep <= 1'b1;
      else if (do_exit) asleep <= 1'b0;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int NCLK  = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_req,
  input logic [NCLK-1:0]  clk_en,
  input logic             io_en,
  input logic             asleep,
  input logic [2:0]       state,
  input logic [CNT_W-1:0] exit_count
);
  // R2
  state_code_chk: assert property (@(posedge clk) disable iff (rst)
    state <= 3'd6);

  // R3
  sleep_dark_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (clk_en == '0) && !io_en);

  // R5
  ramp_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd5) && !sleep_req |=> $countones(clk_en) > $past($countones(clk_en)));

  // R6
  awake_full_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0) |-> io_en && (&clk_en));

  // R8
  abort_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state >= 3'd4) && (state <= 3'd6) && sleep_req |=>
      (state == 3'd1) && $stable(clk_en) && $stable(io_en));

  // R9
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd3) |=> $stable(exit_count));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.NCLK(NCLK), .CNT_W(CNT_W)) u_pwr_seq_chk (
  .clk(clk), .rst(rst), .sleep_req(sleep_req), .clk_en(clk_en),
  .io_en(io_en), .asleep(asleep), .state(state), .exit_count(exit_count)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep_req = 1'b0;
  logic [5:0]  d1 = 6'd3, d2 = 6'd12, d3 = 6'd2, d4 = 6'd41;
  logic [15:0] clk_en;
  logic        io_en, asleep;
  logic [2:0]  state;
  logic [15:0] exit_count;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req),
    .dly_io_off(d1), .dly_clk_off(d2), .dly_clk_on(d3), .dly_io_on(d4),
    .clk_en(clk_en), .io_en(io_en), .asleep(asleep), .state(state),
    .exit_count(exit_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int raw, input int mn);
    return (raw < mn) ? mn : raw;
  endfunction

  function automatic int grp_mask(input int groups);
    int m = 0;
    for (int i = 0; i < 16; i++) if (i / 6 < groups) m |= (1 << i);
    return m;
  endfunction

  // reference model, advanced on every rising edge
  int m_st, m_left, m_grp, m_io, m_slp, m_cnt, m_frz, m_exit;

  task automatic m_enter_sleep_seq();
    m_st = 1; m_left = eff(int'(d1), 1);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_left = 0; m_grp = 3; m_io = 1; m_slp = 0;
      m_cnt = 0; m_frz = 0; m_exit = 0;
    end else begin
      if (!m_frz) m_cnt = (m_cnt + 1) & 16'hFFFF;
      if (m_st >= 4 && sleep_req) begin
        m_enter_sleep_seq();
      end else begin
        case (m_st)
          0: if (sleep_req) m_enter_sleep_seq();
          1: if (m_left == 1) begin m_io = 0; m_st = 2; m_left = eff(int'(d2), 11); end
             else m_left--;
          2: if (m_left == 1) begin m_grp = 0; m_slp = 1; m_st = 3; m_frz = 1; end
             else m_left--;
          3: if (!sleep_req) begin m_slp = 0; m_st = 4; m_left = eff(int'(d3), 1); end
          4: if (m_left == 1) begin m_grp = 1; m_st = 5; end
             else m_left--;
          5: begin
               m_grp++;
               if (m_grp == 3) begin m_st = 6; m_left = eff(int'(d4), 40); end
             end
          6: if (m_left == 1) begin m_io = 1; m_st = 0; m_exit = m_cnt; m_frz = 0; end
             else m_left--;
          default: m_st = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 state",      int'(state),      m_st);
      chk("R5 clk_en",     int'(clk_en),     grp_mask(m_grp));
      chk("R6 io_en",      int'(io_en),      m_io);
      chk("R3 asleep",     int'(asleep),     m_slp);
      chk("R9 exit_count", int'(exit_count), m_exit);
    end
  end

  task automatic go_sleep(input string req, input int exp_edges);
    int n = 0;
    @(negedge clk); sleep_req = 1'b1;
    do begin @(posedge clk); n++; @(negedge clk); end while (!asleep && n < 300);
    chk(req, n, exp_edges);
    chk("R3 clocks off", int'(clk_en), 0);
  endtask

  task automatic go_wake(input int e3, input int e4);
    int n = 0;
    sleep_req = 1'b0;
    do begin @(posedge clk); n++; @(negedge clk); end while (clk_en == 16'h0 && n < 300);
    chk("R4 wake wait", n, e3 + 1);
    chk("R5 group 0", int'(clk_en), 16'h003F);
    @(negedge clk); chk("R5 group 1", int'(clk_en), 16'h0FFF);
    @(negedge clk); chk("R5 group 2", int'(clk_en), 16'hFFFF);
    chk("R5 state", int'(state), 6);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!io_en && n < 300);
    chk("R6 io wait", n, e4);
    chk("R6 state", int'(state), 0);
  endtask

  initial begin
    int held;
    int prev;
    logic [15:0] ce;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 state", int'(state), 0);
    chk("R1 clk_en", int'(clk_en), 16'hFFFF);
    chk("R1 io_en", int'(io_en), 1);
    chk("R1 asleep", int'(asleep), 0);
    chk("R1 exit_count", int'(exit_count), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    // nominal delays
    go_sleep("R3 entry time", 3 + 12 + 1);
    held = int'(exit_count);
    repeat (10) @(negedge clk);
    chk("R9 held in sleep", int'(exit_count), held);
    go_wake(2, 41);
    chk("R9 captured", int'(exit_count), 20 + 3 + 12 + 1 + 1);
    prev = int'(exit_count);
    repeat (5) @(negedge clk);

    // all zero: clamped to 1, 11, 1, 40
    d1 = 0; d2 = 0; d3 = 0; d4 = 0;
    go_sleep("R7 clamped entry", 1 + 11 + 1);
    go_wake(1, 40);
    chk("R9 second capture grows", int'(exit_count > prev), 1);

    // mixed: T2 and T4 below minimum
    d1 = 5; d2 = 5; d3 = 5; d4 = 5;
    go_sleep("R7 mixed entry", 5 + 11 + 1);
    go_wake(5, 40);

    // request dropped during shutdown is ignored
    d1 = 4; d2 = 12; d3 = 1; d4 = 40;
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); @(negedge clk); sleep_req = 1'b0;
    begin
      int n = 2;
      while (!asleep && n < 300) begin @(posedge clk); n++; @(negedge clk); end
      chk("R10 entry completes", n, 4 + 12 + 1);
    end
    while (state != 3'd0) @(negedge clk);

    // abort at each exit stage
    for (int stg = 4; stg <= 6; stg++) begin
      go_sleep("R3 entry before abort", 4 + 12 + 1);
      sleep_req = 1'b0;
      while (int'(state) != stg) @(negedge clk);
      ce = clk_en;
      sleep_req = 1'b1;
      @(negedge clk);
      chk("R8 abort state", int'(state), 1);
      chk("R8 abort clk_en", int'(clk_en), int'(ce));
      chk("R8 abort io_en", int'(io_en), 0);
      while (!asleep) @(negedge clk);
      go_wake(1, 40);
    end

    // largest delays
    d1 = 63; d2 = 63; d3 = 63; d4 = 63;
    go_sleep("R3 max entry", 63 + 63 + 1);
    go_wake(63, 63);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule